// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block runs one access on an external memory bus for a single chip-select region. A request carries an address, a direction flag and write data. The block then walks six phases in a fixed order, named A to F, and the length of each phase is read from a 15-bit timing word. A 6-bit function word enables the region and selects the bus type. It also sets how the external READY line is treated: whether it is used at all, its polarity, and whether it passes through one or two sampling stages.

Phase A is the address setup and phase B is the address strobe. Phases C and D are gaps before the access. Phase E is the strobed access, which can be stretched by READY. Phase F is a recovery tail whose length depends on the direction. In multiplexed modes the shared address/data lines carry the address first and the data later. In demultiplexed modes the shared lines carry only data. A one-cycle done pulse marks the end of the access. Every pin output is registered.

Top module: `ebus_cycle_seq`

## Requirements
- R1: After reset, or when reset is asserted in the middle of an access, all bus outputs, `done` and `rdata` are 0 and the block is idle.
- R2: A request (`req_valid` high while idle) starts an access only when function bit 0 (region enable) is 1. Otherwise it is ignored: `bus_cs` and `done` stay 0.
- R3: Timing bits [6:5] give the phase A length (0 to 3), bits [9:8] give the phase C length (0 to 3) and bit 10 gives the phase D length (0 or 1). A length of 0 skips the phase.
- R4: Timing bit 7 holds the phase B length minus one, so the length is 1 or 2 cycles.
- R5: Timing bits [4:0] hold the phase E length minus one, so the length is 1 to 32 cycles.
- R6: Phase F lasts timing bits [12:11] cycles for a write and bits [14:13] cycles for a read.
- R7: `bus_rd` (read) or `bus_wr` (write) is high exactly during the phase E cycles, and only while `bus_cs` is high.
- R8: When function bit 1 is 1, phase E does not end until READY is seen active. Function bit 3 sets the polarity: 0 means READY is active low, 1 means active high.
- R9: Function bit 2 = 1 samples READY through one register stage. When bit 2 = 0, READY passes through a two-flop synchronizer, which adds one cycle of latency.
- R10: `bus_ale` is high during phases A and B. In multiplexed bus types (function bit 4 = 1), `ad_out` drives the low address bits with `ad_oe` = 1 during phases A to D. In demultiplexed types, `ad_oe` is 0 in those phases.
- R11: Function bit 5 selects a 16-bit bus (1) or an 8-bit bus (0). On an 8-bit bus, the upper byte of both write data driven on `ad_out` and captured `rdata` is 0. Write data is driven with `ad_oe` = 1 during phases E and F.
- R12: For a read, `rdata` captures `bus_din` on the last cycle of phase E, after READY has been seen when READY is enabled.
- R13: `done` is a single-cycle pulse in the cycle after the last phase. It appears L+1 cycles after the accepting edge, where L is the sum of the phase lengths. `bus_cs` is high during all phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| tcfg | input | 15 | Timing word (phase lengths) |
| fcfg | input | 6 | Function word (enable, READY control, bus type) |
| ready_pin | input | 1 | External READY line |
| bus_din | input | DW | Read data from the shared lines |
| bus_cs | output | 1 | Chip select, active high |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| ad_out | output | DW | Shared address/data output value |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_out | output | AW | Separate address bus, held during the access |
| rdata | output | DW | Captured read data |
| done | output | 1 | End-of-access pulse |

## Verification
A vector table sweeps phase lengths from all minimums up to the maximum phase E of 32 cycles. It covers both directions with different read and write tails, and all four bus types. The total duration, the strobe and ALE cycle counts, the first-cycle drive of the shared lines, and the data width together tell apart a wrong phase length, a swapped tail, a skipped-phase mistake and a wrong mux or width decode. Directed READY tests stall phase E and then release it. They measure the release-to-done latency in both sampling modes and both polarities, and change `bus_din` together with READY to show that the capture happens on the final phase E cycle. Further directed tests cover a disabled region and reset during an access.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  localparam int TW = 15;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_B    = 3'd2,
    PH_C    = 3'd3,
    PH_D    = 3'd4,
    PH_E    = 3'd5,
    PH_F    = 3'd6,
    PH_END  = 3'd7
  } phase_t;

  typedef struct packed {
    logic [1:0] a;
    logic       b_m1;
    logic [1:0] c;
    logic       d;
    logic [4:0] e_m1;
    logic [1:0] f_rd;
    logic [1:0] f_wr;
  } tim_t;

  function automatic tim_t unpack_tim(input logic [TW-1:0] w);
    tim_t t;
    t.e_m1 = w[4:0];
    t.a    = w[6:5];
    t.b_m1 = w[7];
    t.c    = w[9:8];
    t.d    = w[10];
    t.f_wr = w[12:11];
    t.f_rd = w[14:13];
    return t;
  endfunction

  // Number of cycles spent in a phase (0 means the phase is skipped).
  function automatic logic [5:0] phase_len(input phase_t p, input tim_t t, input logic wr);
    logic [5:0] n;
    case (p)
      PH_A:    n = {4'd0, t.a};
      PH_B:    n = {5'd0, t.b_m1} + 6'd1;
      PH_C:    n = {4'd0, t.c};
      PH_D:    n = {5'd0, t.d};
      PH_E:    n = {1'b0, t.e_m1} + 6'd1;
      PH_F:    n = wr ? {4'd0, t.f_wr} : {4'd0, t.f_rd};
      PH_END:  n = 6'd1;
      default: n = 6'd0;
    endcase
    return n;
  endfunction

  // First phase after p that has a non-zero length; the end state otherwise.
  function automatic phase_t next_phase(input phase_t p, input tim_t t, input logic wr);
    phase_t r;
    r = PH_END;
    for (int i = 6; i >= 1; i--) begin
      if (i > int'(p) && phase_len(phase_t'(3'(i)), t, wr) != 6'd0)
        r = phase_t'(3'(i));
    end
    return r;
  endfunction

endpackage

// File: rtl/ebs_ready_cond.sv
module ebs_ready_cond (
  input  logic clk,
  input  logic rst,
  input  logic ready_pin,
  input  logic sync_mode,
  input  logic pol_high,
  output logic rdy_ok
);

  logic norm;
  logic stage1;
  logic stage2;

  assign norm = pol_high ? ready_pin : ~ready_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= norm;
      stage2 <= stage1;
    end
  end

  // One stage when synchronous sampling is chosen, two otherwise.
  assign rdy_ok = sync_mode ? stage1 : stage2;

endmodule

// File: rtl/ebs_phase_ctrl.sv
module ebs_phase_ctrl
  import ebs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] tcfg,
  input  logic          cs_en,
  input  logic          rdy_en,
  input  logic [1:0]    btype,
  input  logic          rdy_ok,
  output phase_t        ph,
  output phase_t        ph_nxt,
  output logic          cap,
  output logic          sel_write,
  output logic [AW-1:0] sel_addr,
  output logic [DW-1:0] sel_wdata,
  output logic [1:0]    sel_btype
);

  localparam int CW = 5;

  tim_t          h_tim;
  tim_t          act_tim;
  logic          h_wr;
  logic          h_rdy;
  logic [1:0]    h_bt;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wd;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [5:0]    len_nxt;
  logic          accept;
  logic          stay_e;
  logic          adv;

  always_comb begin
    accept    = (ph == PH_IDLE) && req_valid && cs_en;
    act_tim   = accept ? unpack_tim(tcfg) : h_tim;
    sel_write = accept ? req_write : h_wr;
    sel_addr  = accept ? req_addr  : h_addr;
    sel_wdata = accept ? req_wdata : h_wd;
    sel_btype = accept ? btype     : h_bt;

    stay_e = (ph == PH_E) && h_rdy && !rdy_ok;
    adv    = (ph != PH_IDLE) && (cnt == '0) && !stay_e;

    ph_nxt = ph;
    if (ph == PH_IDLE) begin
      if (accept) ph_nxt = next_phase(PH_IDLE, act_tim, sel_write);
    end else if (adv) begin
      ph_nxt = (ph == PH_END) ? PH_IDLE : next_phase(ph, h_tim, h_wr);
    end

    len_nxt = phase_len(ph_nxt, act_tim, sel_write);
    cnt_nxt = cnt;
    if (ph_nxt != ph)
      cnt_nxt = (len_nxt == 6'd0) ? '0 : CW'(len_nxt - 6'd1);
    else if (cnt != '0)
      cnt_nxt = cnt - 1'b1;

    cap = (ph == PH_E) && adv && !h_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      h_tim  <= '0;
      h_wr   <= 1'b0;
      h_rdy  <= 1'b0;
      h_bt   <= '0;
      h_addr <= '0;
      h_wd   <= '0;
    end else begin
      ph  <= ph_nxt;
      cnt <= cnt_nxt;
      if (accept) begin
        h_tim  <= act_tim;
        h_wr   <= req_write;
        h_rdy  <= rdy_en;
        h_bt   <= btype;
        h_addr <= req_addr;
        h_wd   <= req_wdata;
      end
    end
  end

  // R2: a disabled region never leaves idle
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !cs_en) |=> (ph == PH_IDLE));

  // R8: phase E is held while READY is enabled and not yet seen
  assert_wait_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_E && h_rdy && !rdy_ok) |=> (ph == PH_E));

  // R3: phases only move forward through the fixed order, or back to idle
  assert_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_IDLE && ph != PH_END && ph_nxt != ph) |-> (ph_nxt > ph));

endmodule

// File: rtl/ebs_pin_drv.sv
module ebs_pin_drv
  import ebs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        ph_nxt,
  input  logic          sel_write,
  input  logic [AW-1:0] sel_addr,
  input  logic [DW-1:0] sel_wdata,
  input  logic [1:0]    sel_btype,
  input  logic          cap,
  input  logic [DW-1:0] bus_din,
  output logic          bus_cs,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] rdata
);

  localparam int HW = DW / 2;

  logic          busy_d;
  logic          early_d;
  logic          mux;
  logic          wide;
  logic [DW-1:0] wd_fit;
  logic [DW-1:0] din_fit;
  logic [DW-1:0] ad_d;
  logic          oe_d;

  always_comb begin
    busy_d  = (ph_nxt != PH_IDLE) && (ph_nxt != PH_END);
    early_d = (ph_nxt == PH_A) || (ph_nxt == PH_B) || (ph_nxt == PH_C) || (ph_nxt == PH_D);
    mux     = sel_btype[0];
    wide    = sel_btype[1];
    wd_fit  = wide ? sel_wdata : {{(DW-HW){1'b0}}, sel_wdata[HW-1:0]};
    din_fit = wide ? bus_din   : {{(DW-HW){1'b0}}, bus_din[HW-1:0]};
    if (mux && early_d) begin
      oe_d = 1'b1;
      ad_d = sel_addr[DW-1:0];
    end else if (sel_write && (ph_nxt == PH_E || ph_nxt == PH_F)) begin
      oe_d = 1'b1;
      ad_d = wd_fit;
    end else begin
      oe_d = 1'b0;
      ad_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs   <= 1'b0;
      bus_ale  <= 1'b0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      addr_out <= '0;
      rdata    <= '0;
    end else begin
      bus_cs   <= busy_d;
      bus_ale  <= (ph_nxt == PH_A) || (ph_nxt == PH_B);
      bus_rd   <= (ph_nxt == PH_E) && !sel_write;
      bus_wr   <= (ph_nxt == PH_E) && sel_write;
      ad_out   <= ad_d;
      ad_oe    <= oe_d;
      addr_out <= busy_d ? sel_addr : '0;
      if (cap) rdata <= din_fit;
    end
  end

  // R7: strobes only inside an active chip select
  assert_rw_in_cs_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_cs);

  // R10: address strobe never overlaps the access strobes
  assert_ale_apart_R10: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> !(bus_rd || bus_wr));

endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
  import ebs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [14:0]   tcfg,
  input  logic [5:0]    fcfg,
  input  logic          ready_pin,
  input  logic [DW-1:0] bus_din,
  output logic          bus_cs,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] rdata,
  output logic          done
);

  phase_t        ph;
  phase_t        ph_nxt;
  logic          rdy_ok;
  logic          cap;
  logic          sel_write;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic [1:0]    sel_btype;

  ebs_ready_cond u_rdy (
    .clk       (clk),
    .rst       (rst),
    .ready_pin (ready_pin),
    .sync_mode (fcfg[2]),
    .pol_high  (fcfg[3]),
    .rdy_ok    (rdy_ok)
  );

  ebs_phase_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .tcfg      (tcfg),
    .cs_en     (fcfg[0]),
    .rdy_en    (fcfg[1]),
    .btype     (fcfg[5:4]),
    .rdy_ok    (rdy_ok),
    .ph        (ph),
    .ph_nxt    (ph_nxt),
    .cap       (cap),
    .sel_write (sel_write),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata),
    .sel_btype (sel_btype)
  );

  ebs_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .ph_nxt    (ph_nxt),
    .sel_write (sel_write),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata),
    .sel_btype (sel_btype),
    .cap       (cap),
    .bus_din   (bus_din),
    .bus_cs    (bus_cs),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .addr_out  (addr_out),
    .rdata     (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= (ph_nxt == PH_END);
  end

  // R13: done lasts exactly one cycle
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13: chip select drops when done is raised
  assert_cs_off_at_done_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_cs);

endmodule

// File: tb/sim_ebus_cycle_seq.sv
`timescale 1ns/1ps
module sim_ebus_cycle_seq;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [14:0]   tcfg = '0;
  logic [5:0]    fcfg = '0;
  logic          ready_pin = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic          bus_cs, bus_ale, bus_rd, bus_wr, ad_oe, done;
  logic [DW-1:0] ad_out, rdata;
  logic [AW-1:0] addr_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  ebus_cycle_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .tcfg(tcfg), .fcfg(fcfg),
    .ready_pin(ready_pin), .bus_din(bus_din), .bus_cs(bus_cs), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_out(addr_out), .rdata(rdata), .done(done)
  );

  typedef struct packed {
    logic [1:0]  a;
    logic [1:0]  b;
    logic [1:0]  c;
    logic        d;
    logic [5:0]  e;
    logic [1:0]  fr;
    logic [1:0]  fw;
    logic [1:0]  bt;
    logic        wr;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [15:0] din;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 2'd2, 2'd0, 1'b0, 6'd10, 2'd0, 2'd3, 2'd3, 1'b1, 24'h12A5C3, 16'hBEEF, 16'h0000},
    '{2'd0, 2'd1, 2'd0, 1'b0, 6'd1,  2'd0, 2'd0, 2'd0, 1'b0, 24'h000010, 16'h0000, 16'hA55A},
    '{2'd1, 2'd1, 2'd3, 1'b1, 6'd32, 2'd2, 2'd1, 2'd2, 1'b0, 24'h3F0004, 16'h0000, 16'h1234},
    '{2'd2, 2'd2, 2'd1, 1'b1, 6'd5,  2'd3, 2'd0, 2'd1, 1'b1, 24'h00BEE8, 16'hC3A7, 16'h0000},
    '{2'd2, 2'd2, 2'd1, 1'b1, 6'd5,  2'd3, 2'd0, 2'd1, 1'b0, 24'h00BEE8, 16'h0000, 16'h7E81},
    '{2'd0, 2'd1, 2'd2, 1'b0, 6'd4,  2'd1, 2'd2, 2'd3, 1'b0, 24'hFF1357, 16'h0000, 16'hF00D}
  };

  function automatic logic [14:0] mk_t(input vec_t v);
    logic [4:0] em1;
    logic       bm1;
    em1 = 5'(v.e - 6'd1);
    bm1 = (v.b == 2'd2);
    return {v.fr, v.fw, v.d, v.c, bm1, v.a, em1};
  endfunction

  function automatic int exp_len(input vec_t v);
    return int'(v.a) + int'(v.b) + int'(v.c) + int'(v.d) + int'(v.e) +
           (v.wr ? int'(v.fw) : int'(v.fr));
  endfunction

  function automatic logic [15:0] fit(input logic [1:0] bt, input logic [15:0] x);
    return bt[1] ? x : {8'h00, x[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input vec_t v, input logic [5:0] f);
    @(negedge clk);
    tcfg      = mk_t(v);
    fcfg      = f;
    req_addr  = v.addr;
    req_write = v.wr;
    req_wdata = v.wd;
    bus_din   = v.din;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Counts cycles from the accepting edge until done (first sample is count 1).
  task automatic run_vec(input vec_t v, input int idx);
    int n = 0, rwc = 0, alec = 0;
    bit wd_ok = 1;
    logic f_oe;
    logic [15:0] f_ad;
    logic [5:0]  f;
    f = {v.bt, 1'b0, 1'b0, 1'b0, 1'b1};
    start_req(v, f);
    f_oe = ad_oe;
    f_ad = ad_out;
    forever begin
      n++;
      if (bus_rd || bus_wr) rwc++;
      if (bus_ale) alec++;
      if (bus_wr && !(ad_oe && ad_out == fit(v.bt, v.wd))) wd_ok = 0;
      if (done || n > 200) break;
      @(negedge clk);
    end
    chk(n == exp_len(v) + 1, $sformatf("R3/R4 R5 R6 R13 total length vec %0d", idx), n, exp_len(v) + 1);
    chk(rwc == int'(v.e), $sformatf("R7 strobe cycles vec %0d", idx), rwc, v.e);
    chk(alec == int'(v.a) + int'(v.b), $sformatf("R10 ale cycles vec %0d", idx), alec, v.a + v.b);
    if (v.bt[0])
      chk(f_oe && f_ad == v.addr[15:0], $sformatf("R10 mux address drive vec %0d", idx), {f_oe, f_ad}, {1'b1, v.addr[15:0]});
    else
      chk(!f_oe, $sformatf("R10 demux no early drive vec %0d", idx), f_oe, 0);
    if (v.wr)
      chk(wd_ok, $sformatf("R11 write data width vec %0d", idx), wd_ok, 1);
    else
      chk(rdata == fit(v.bt, v.din), $sformatf("R11 R12 read data vec %0d", idx), rdata, fit(v.bt, v.din));
  endtask

  // Stalls phase E with READY inactive, then releases it; returns cycles to done.
  task automatic rdy_case(input logic sync, input logic pol, input int exp_m, input string tag);
    vec_t v;
    int m = 0, seen = 0;
    bit rd_held;
    v = '{2'd0, 2'd1, 2'd0, 1'b0, 6'd2, 2'd1, 2'd0, 2'd3, 1'b0, 24'h000100, 16'h0000, 16'hDEAD};
    @(negedge clk);
    fcfg      = {2'b11, pol, sync, 1'b1, 1'b1};
    ready_pin = ~pol;
    repeat (4) @(negedge clk);
    start_req(v, {2'b11, pol, sync, 1'b1, 1'b1});
    for (int i = 0; i < 10; i++) begin
      if (done) seen++;
      @(negedge clk);
    end
    rd_held = bus_rd;
    chk(seen == 0 && rd_held, {tag, " R8 stalled without READY"}, {seen[7:0], rd_held}, 9'h001);
    ready_pin = pol;
    bus_din   = 16'h5AC3;
    forever begin
      @(negedge clk);
      m++;
      if (done || m > 50) break;
    end
    chk(m == exp_m, {tag, " R9 release latency"}, m, exp_m);
    chk(rdata == 16'h5AC3, {tag, " R12 capture after READY"}, rdata, 16'h5AC3);
    ready_pin = ~pol;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({bus_cs, bus_ale, bus_rd, bus_wr, ad_oe, done} == 6'b0 && ad_out == 0 && rdata == 0 && addr_out == 0,
        "R1 reset outputs", {bus_cs, bus_ale, bus_rd, bus_wr, ad_oe, done}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2: disabled region ignores the request
    begin
      vec_t v;
      int act = 0;
      v = VECS[1];
      start_req(v, 6'b110000);
      for (int i = 0; i < 8; i++) begin
        if (bus_cs || done) act++;
        @(negedge clk);
      end
      chk(act == 0, "R2 disabled region ignored", act, 0);
    end

    // R8/R9: stall and release in each sampling mode and polarity
    rdy_case(1'b1, 1'b0, 3, "sync low");
    rdy_case(1'b0, 1'b0, 4, "async low");
    rdy_case(1'b1, 1'b1, 3, "sync high");

    // R8: READY already active does not lengthen the access
    begin
      vec_t v;
      int n = 0;
      v = '{2'd1, 2'd1, 2'd0, 1'b0, 6'd3, 2'd2, 2'd0, 2'd2, 1'b0, 24'h000200, 16'h0000, 16'h4321};
      @(negedge clk);
      fcfg = 6'b100011;
      ready_pin = 1'b0;
      repeat (4) @(negedge clk);
      start_req(v, 6'b100011);
      forever begin
        n++;
        if (done || n > 100) break;
        @(negedge clk);
      end
      chk(n == exp_len(v) + 1, "R8 ready already active", n, exp_len(v) + 1);
      ready_pin = 1'b1;
    end

    // R1: reset in the middle of an access
    begin
      vec_t v;
      int act = 0;
      v = VECS[2];
      start_req(v, {v.bt, 4'b0001});
      repeat (5) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk({bus_cs, bus_ale, bus_rd, bus_wr, ad_oe, done} == 6'b0 && addr_out == 0,
          "R1 reset during access", {bus_cs, bus_rd, ad_oe}, 0);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (bus_cs || done) act++;
      end
      chk(act == 0, "R1 idle after mid-access reset", act, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule